// File: doc/BRIEF.md
# Global 64-bit Counter with Periodic Comparator

This block holds a 64-bit free-running counter that software reads and writes through a small 32-bit register bus, together with one 64-bit compare channel. When the counter, while running, equals the compare value with the channel enabled, an interrupt status flag is raised. The flag drives the interrupt output when its enable bit is set. In one-shot use the compare value stays where it is. In periodic use the compare value moves forward by a programmed increment on every hit, so events repeat at a fixed spacing in cycles.

Every write to a counter half, a compare half, the increment or the control register is confirmed by a sticky write-status bit. The bit appears a fixed number of cycles after the write, which models a synchronised update, and software clears it by writing 1. Software can therefore poll for completion before it trusts a new setting. Bus reads are registered: the data appears on the cycle after the read strobe.

Top module: `gtimer_cmp`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The counter halves sit at offsets 0x100 (bits 31:0) and 0x104 (bits 63:32). A write loads only the addressed half and leaves the other half unchanged. While stopped, the counter holds its value.
- R3: While control bit 8 (run) at offset 0x240 is set, the counter gains exactly 1 on every cycle. In a cycle that also carries a counter-half write, the written half takes the bus data and the other half holds.
- R4: The count carries from bit 31 into bit 32. It is a single 64-bit count.
- R5: A hit is full 64-bit equality between counter and compare value (0x200 low, 0x204 high). It counts only while run and control bit 0 (compare enable) are both set. A hit sets interrupt status bit 0 at 0x244. With control bit 1 clear, the compare value is left unchanged.
- R6: With control bit 1 (auto-increment) set, each hit adds the 32-bit increment at 0x208, zero-extended, to the compare value.
- R7: Writing 1 to status bit 0 clears it, and writing 0 there has no effect. A hit in the same cycle as the clear wins.
- R8: `irq` is high exactly while status bit 0 and enable bit 0 at 0x248 are both set. The enable register keeps only bit 0.
- R9: Write-status bits set `WST_LAT` (default 2) clock edges after the edge that accepts the write. At 0x24C, bit 0 is compare low, bit 1 compare high, bit 2 increment and bit 16 control. At 0x110, bit 0 is counter low and bit 1 counter high.
- R10: Write-status bits stay set until software writes 1 to them. Writing 0 leaves them unchanged.
- R11: `bus_rdata` shows, one cycle after the read strobe, the value the register held at the accepting edge, and 0 otherwise. Control reads back only bits 8, 1 and 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Compare interrupt, active high |

## Verification
The bench probes the write-status latency cycle by cycle; a design that set the bit one edge early or late would read 1 where the model expects 0, or the reverse. It starts the counter at a low half of all ones, where a missing carry would leave the high half unchanged. It sets a compare value that matches in its low half only, where a 32-bit comparator would fire. It runs an auto-increment window whose final compare value shows whether the increment was added once per hit, skipped, or applied while stopped. It also writes to a half while the counter runs, where a design that dropped the increment or corrupted the other half would show up.

// File: rtl/gtimer_pkg.sv
// Shared constants and types for the global counter/comparator block.
// Assumes a 32-bit register bus. Offsets and bit positions are the
// software-visible contract, so they are fixed here.
package gtimer_pkg;
    localparam int REG_W = 32;
    localparam int CNT_W = 2 * REG_W;

    localparam logic [11:0] OFF_CNT_LO  = 12'h100;
    localparam logic [11:0] OFF_CNT_HI  = 12'h104;
    localparam logic [11:0] OFF_CNT_WST = 12'h110;
    localparam logic [11:0] OFF_CMP_LO  = 12'h200;
    localparam logic [11:0] OFF_CMP_HI  = 12'h204;
    localparam logic [11:0] OFF_CMP_INC = 12'h208;
    localparam logic [11:0] OFF_CTRL    = 12'h240;
    localparam logic [11:0] OFF_ISTAT   = 12'h244;
    localparam logic [11:0] OFF_IENB    = 12'h248;
    localparam logic [11:0] OFF_GEN_WST = 12'h24C;

    localparam int CTRL_CMPEN_BIT = 0;
    localparam int CTRL_AUTO_BIT  = 1;
    localparam int CTRL_RUN_BIT   = 8;

    localparam int GWST_CMP_LO = 0;
    localparam int GWST_CMP_HI = 1;
    localparam int GWST_INC    = 2;
    localparam int GWST_CTRL   = 16;
    localparam int GWST_N      = 4;

    localparam int CWST_LO = 0;
    localparam int CWST_HI = 1;
    localparam int CWST_N  = 2;

    // One strobe per register, asserted in the cycle of a bus write to it.
    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic cnt_wst;
        logic cmp_lo;
        logic cmp_hi;
        logic cmp_inc;
        logic ctrl;
        logic istat;
        logic ienb;
        logic gen_wst;
    } reg_sel_t;

    typedef struct packed {
        logic run;
        logic auto_inc;
        logic cmp_en;
    } ctrl_t;
endpackage

// File: rtl/gtimer_wstat.sv
// Sticky write-confirmation bits. Each bit is set LAT clock edges after its
// hit strobe and is cleared by its clear strobe; a set wins over a clear.
// Assumes LAT >= 1.
module gtimer_wstat #(
    parameter int N   = 4,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] clr,
    output logic [N-1:0] sticky
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [LAT-1:0] pipe;

        if (LAT == 1) begin : g_one
            // Single-stage delay of the write strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= hit[b];
            end
        end else begin : g_multi
            // Multi-stage delay line for the write strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[LAT-2:0], hit[b]};
            end
        end

        // Sticky status: set by the delayed strobe, cleared by write-one.
        always_ff @(posedge clk) begin
            if (!rst_n)              sticky[b] <= 1'b0;
            else if (pipe[LAT-1])    sticky[b] <= 1'b1;
            else if (clr[b])         sticky[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/gtimer_count.sv
// 64-bit free-running counter. Either 32-bit half can be loaded; a load
// holds the other half for that cycle. Counts by one while run is high.
module gtimer_count
    import gtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);
    // Counter update: a half load takes priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wr_lo) cnt <= {cnt[CNT_W-1:REG_W], wdata};
        else if (wr_hi) cnt <= {wdata, cnt[REG_W-1:0]};
        else if (run)   cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/gtimer_match.sv
// Compare channel: holds the 64-bit compare value and the increment, flags
// a hit on full equality while running and enabled, optionally advances
// the compare value, and keeps the interrupt status bit.
module gtimer_match
    import gtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  ctrl_t            ctrl,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_inc,
    input  logic             istat_clr,
    input  logic [REG_W-1:0] wdata,
    output logic [CNT_W-1:0] cmp,
    output logic [REG_W-1:0] incr,
    output logic             hit,
    output logic             istat
);
    // Hit detection on the live counter.
    always_comb hit = ctrl.run && ctrl.cmp_en && (cnt == cmp);

    // Compare value: software load first, then periodic advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cmp <= '0;
        else if (wr_lo)                cmp <= {cmp[CNT_W-1:REG_W], wdata};
        else if (wr_hi)                cmp <= {wdata, cmp[REG_W-1:0]};
        else if (hit && ctrl.auto_inc) cmp <= cmp + {{REG_W{1'b0}}, incr};
    end

    // Increment register.
    always_ff @(posedge clk) begin
        if (!rst_n)      incr <= '0;
        else if (wr_inc) incr <= wdata;
    end

    // Interrupt status: hit sets, write-one clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         istat <= 1'b0;
        else if (hit)       istat <= 1'b1;
        else if (istat_clr) istat <= 1'b0;
    end
endmodule

// File: rtl/gtimer_regs.sv
// Bus decode, control and interrupt-enable storage, and the registered
// read mux. Assumes single-cycle write and read strobes.
module gtimer_regs
    import gtimer_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  cmp,
    input  logic [REG_W-1:0]  incr,
    input  logic              istat,
    input  logic [GWST_N-1:0] gen_wst,
    input  logic [CWST_N-1:0] cnt_wst,
    output reg_sel_t          sel,
    output ctrl_t             ctrl,
    output logic              ienb,
    output logic [REG_W-1:0]  rdata
);
    logic [REG_W-1:0] rd_mux;

    // Write decode into one strobe per register.
    always_comb begin
        sel = '0;
        if (wr_en) begin
            sel.cnt_lo  = (addr == ADDR_W'(OFF_CNT_LO));
            sel.cnt_hi  = (addr == ADDR_W'(OFF_CNT_HI));
            sel.cnt_wst = (addr == ADDR_W'(OFF_CNT_WST));
            sel.cmp_lo  = (addr == ADDR_W'(OFF_CMP_LO));
            sel.cmp_hi  = (addr == ADDR_W'(OFF_CMP_HI));
            sel.cmp_inc = (addr == ADDR_W'(OFF_CMP_INC));
            sel.ctrl    = (addr == ADDR_W'(OFF_CTRL));
            sel.istat   = (addr == ADDR_W'(OFF_ISTAT));
            sel.ienb    = (addr == ADDR_W'(OFF_IENB));
            sel.gen_wst = (addr == ADDR_W'(OFF_GEN_WST));
        end
    end

    // Control register, three live bits.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else if (sel.ctrl) begin
            ctrl.run      <= wdata[CTRL_RUN_BIT];
            ctrl.auto_inc <= wdata[CTRL_AUTO_BIT];
            ctrl.cmp_en   <= wdata[CTRL_CMPEN_BIT];
        end
    end

    // Interrupt enable, bit 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n)        ienb <= 1'b0;
        else if (sel.ienb) ienb <= wdata[0];
    end

    // Read selection by offset; unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        case (addr)
            ADDR_W'(OFF_CNT_LO):  rd_mux = cnt[REG_W-1:0];
            ADDR_W'(OFF_CNT_HI):  rd_mux = cnt[CNT_W-1:REG_W];
            ADDR_W'(OFF_CMP_LO):  rd_mux = cmp[REG_W-1:0];
            ADDR_W'(OFF_CMP_HI):  rd_mux = cmp[CNT_W-1:REG_W];
            ADDR_W'(OFF_CMP_INC): rd_mux = incr;
            ADDR_W'(OFF_ISTAT):   rd_mux[0] = istat;
            ADDR_W'(OFF_IENB):    rd_mux[0] = ienb;
            ADDR_W'(OFF_CTRL): begin
                rd_mux[CTRL_RUN_BIT]   = ctrl.run;
                rd_mux[CTRL_AUTO_BIT]  = ctrl.auto_inc;
                rd_mux[CTRL_CMPEN_BIT] = ctrl.cmp_en;
            end
            ADDR_W'(OFF_CNT_WST): begin
                rd_mux[CWST_LO] = cnt_wst[CWST_LO];
                rd_mux[CWST_HI] = cnt_wst[CWST_HI];
            end
            ADDR_W'(OFF_GEN_WST): begin
                rd_mux[GWST_CMP_LO] = gen_wst[0];
                rd_mux[GWST_CMP_HI] = gen_wst[1];
                rd_mux[GWST_INC]    = gen_wst[2];
                rd_mux[GWST_CTRL]   = gen_wst[3];
            end
            default: rd_mux = '0;
        endcase
    end

    // Registered read data, zero when no read was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_en ? rd_mux : '0;
    end
endmodule

// File: rtl/gtimer_cmp.sv
// Top of the global counter/comparator block: wires the register file,
// counter, compare channel and both write-status groups together.
// Assumes one clock domain and synchronous active-low reset.
module gtimer_cmp
    import gtimer_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int WST_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    reg_sel_t          sel;
    ctrl_t             ctrl;
    logic              ienb;
    logic              istat;
    logic              hit;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic [REG_W-1:0]  incr;
    logic [GWST_N-1:0] gen_wst;
    logic [CWST_N-1:0] cnt_wst;
    logic [GWST_N-1:0] gen_hit;
    logic [GWST_N-1:0] gen_clr;
    logic [CWST_N-1:0] cnt_hit;
    logic [CWST_N-1:0] cnt_clr;
    logic              cnt_wr;
    logic              cmp_wr;

    // Group the strobes and write-one-clear masks for the status trackers.
    always_comb begin
        gen_hit = {sel.ctrl, sel.cmp_inc, sel.cmp_hi, sel.cmp_lo};
        gen_clr = {GWST_N{sel.gen_wst}} &
                  {bus_wdata[GWST_CTRL], bus_wdata[GWST_INC],
                   bus_wdata[GWST_CMP_HI], bus_wdata[GWST_CMP_LO]};
        cnt_hit = {sel.cnt_hi, sel.cnt_lo};
        cnt_clr = {CWST_N{sel.cnt_wst}} &
                  {bus_wdata[CWST_HI], bus_wdata[CWST_LO]};
        cnt_wr  = sel.cnt_lo | sel.cnt_hi;
        cmp_wr  = sel.cmp_lo | sel.cmp_hi;
    end

    // Interrupt output gated by its enable.
    always_comb irq = istat & ienb;

    gtimer_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr),
        .rd_en(bus_rd), .wdata(bus_wdata), .cnt(cnt), .cmp(cmp),
        .incr(incr), .istat(istat), .gen_wst(gen_wst), .cnt_wst(cnt_wst),
        .sel(sel), .ctrl(ctrl), .ienb(ienb), .rdata(bus_rdata)
    );

    gtimer_count count_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .wr_lo(sel.cnt_lo),
        .wr_hi(sel.cnt_hi), .wdata(bus_wdata), .cnt(cnt)
    );

    gtimer_match match_i (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .ctrl(ctrl),
        .wr_lo(sel.cmp_lo), .wr_hi(sel.cmp_hi), .wr_inc(sel.cmp_inc),
        .istat_clr(sel.istat & bus_wdata[0]), .wdata(bus_wdata),
        .cmp(cmp), .incr(incr), .hit(hit), .istat(istat)
    );

    gtimer_wstat #(.N(GWST_N), .LAT(WST_LAT)) gen_wst_i (
        .clk(clk), .rst_n(rst_n), .hit(gen_hit), .clr(gen_clr),
        .sticky(gen_wst)
    );

    gtimer_wstat #(.N(CWST_N), .LAT(WST_LAT)) cnt_wst_i (
        .clk(clk), .rst_n(rst_n), .hit(cnt_hit), .clr(cnt_clr),
        .sticky(cnt_wst)
    );
endmodule

// File: rtl/gtimer_cmp_chk.sv
// Property checker for gtimer_cmp, attached by bind below.
module gtimer_cmp_chk
    import gtimer_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [REG_W-1:0]  incr,
    input logic              run,
    input logic              auto_inc,
    input logic              hit,
    input logic              cnt_wr,
    input logic              cmp_wr,
    input logic              istat,
    input logic              gwst0,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata
);
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    // R6
    cmp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && auto_inc && !cmp_wr) |=>
        (cmp == $past(cmp) + {{REG_W{1'b0}}, $past(incr)}));

    // R5
    cmp_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !auto_inc && !cmp_wr) |=> $stable(cmp));

    // R7
    istat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat) |-> $past(hit));

    // R10
    wst_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gwst0) |->
        $past(wr && addr == ADDR_W'(OFF_GEN_WST) && wdata[GWST_CMP_LO]));
endmodule

bind gtimer_cmp gtimer_cmp_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp), .incr(incr),
    .run(ctrl.run), .auto_inc(ctrl.auto_inc), .hit(hit), .cnt_wr(cnt_wr),
    .cmp_wr(cmp_wr), .istat(istat), .gwst0(gen_wst[0]), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata)
);

// File: tb/gtimer_cmp_tb_top.sv
// Scoreboard bench: read tasks queue expected values, a monitor compares.
module gtimer_cmp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    typedef struct {
        logic [31:0] exp;
        logic [11:0] addr;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    gtimer_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.exp = e; it.addr = a; it.tag = tag;
        q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_chk++;
        if (irq !== e) begin
            n_err++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq, e);
        end
    endtask

    // Monitor: compare read data one step after the accepting edge.
    always @(posedge clk) begin
        if (rst_n && bus_rd) begin
            #1;
            if (q.size() == 0) begin
                n_err++;
                $display("FAIL scoreboard read with no expectation actual %h expected none", bus_rdata);
            end else begin
                cur = q.pop_front();
                n_chk++;
                if (bus_rdata !== cur.exp) begin
                    n_err++;
                    $display("FAIL %s @%h actual %h expected %h",
                             cur.tag, cur.addr, bus_rdata, cur.exp);
                end
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog expired actual hung expected done");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk_irq(1'b0, "R1");
        foreach (reg_list[i]) rd(reg_list[i], 32'h0, "R1");

        // R2 half writes, other half held
        wr(12'h100, 32'hDEAD_BEEF);
        wr(12'h104, 32'h0000_1234);
        rd(12'h100, 32'hDEAD_BEEF, "R2");
        rd(12'h104, 32'h0000_1234, "R2");
        wr(12'h100, 32'h0000_0007);
        rd(12'h104, 32'h0000_1234, "R2");
        idle(3);
        rd(12'h100, 32'h0000_0007, "R2");

        // R3 counting: start, 7 idle cycles, stop gives 8 increments
        wr(12'h100, 32'd100);
        wr(12'h104, 32'd0);
        wr(12'h240, 32'h100);
        idle(7);
        wr(12'h240, 32'h0);
        rd(12'h100, 32'd108, "R3");
        // R3 half write while running
        wr(12'h104, 32'd3);
        wr(12'h240, 32'h100);
        idle(2);
        wr(12'h100, 32'd500);
        wr(12'h240, 32'h0);
        rd(12'h100, 32'd501, "R3");
        rd(12'h104, 32'd3, "R3");

        // R4 carry into the high half
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h104, 32'd5);
        wr(12'h240, 32'h100);
        wr(12'h240, 32'h0);
        rd(12'h100, 32'h0, "R4");
        rd(12'h104, 32'd6, "R4");

        // R5 low half equal, high half differs: no hit
        wr(12'h248, 32'h1);
        wr(12'h100, 32'd10);
        wr(12'h104, 32'd0);
        wr(12'h200, 32'd20);
        wr(12'h204, 32'd1);
        wr(12'h240, 32'h101);
        idle(30);
        chk_irq(1'b0, "R5 upper mismatch");
        wr(12'h240, 32'h0);
        rd(12'h244, 32'h0, "R5 upper mismatch");
        // R5 compare disabled: no hit
        wr(12'h204, 32'd0);
        wr(12'h100, 32'd10);
        wr(12'h240, 32'h100);
        idle(15);
        wr(12'h240, 32'h0);
        rd(12'h244, 32'h0, "R5 disabled");
        // R5 one-shot hit at count 20
        wr(12'h100, 32'd10);
        wr(12'h240, 32'h101);
        idle(5);
        chk_irq(1'b0, "R5 early");
        idle(10);
        chk_irq(1'b1, "R5 hit");
        wr(12'h240, 32'h0);
        rd(12'h200, 32'd20, "R5 one-shot cmp");
        rd(12'h244, 32'h1, "R5 status");

        // R8 enable gating
        wr(12'h248, 32'h0);
        chk_irq(1'b0, "R8 disabled");
        rd(12'h244, 32'h1, "R8 status kept");
        wr(12'h248, 32'hFF);
        chk_irq(1'b1, "R8 enabled");
        rd(12'h248, 32'h1, "R8 enable bit only");

        // R7 write-one clear
        wr(12'h244, 32'h0);
        chk_irq(1'b1, "R7 write zero");
        wr(12'h244, 32'h1);
        chk_irq(1'b0, "R7 clear");
        rd(12'h244, 32'h0, "R7");

        // R6 auto-increment: hits at 5 and 13, stop at 21
        wr(12'h100, 32'd0);
        wr(12'h104, 32'd0);
        wr(12'h200, 32'd5);
        wr(12'h204, 32'd0);
        wr(12'h208, 32'd8);
        wr(12'h240, 32'h103);
        idle(20);
        wr(12'h240, 32'h0);
        rd(12'h200, 32'd21, "R6 cmp low");
        rd(12'h204, 32'd0, "R6 cmp high");
        rd(12'h100, 32'd21, "R6 count");
        rd(12'h244, 32'h1, "R6 status");
        wr(12'h244, 32'h1);

        // R11 control readback and unmapped offset
        wr(12'h240, 32'hFFFF_FEFC);
        rd(12'h240, 32'h0, "R11 ctrl masked");
        wr(12'h240, 32'h0000_0103);
        wr(12'h240, 32'h0000_0000);
        rd(12'h300, 32'h0, "R11 unmapped");
        rd(12'h208, 32'd8, "R11 incr");

        // R9 and R10 write-status tracking
        idle(4);
        wr(12'h24C, 32'hFFFF_FFFF);
        wr(12'h110, 32'hFFFF_FFFF);
        rd(12'h24C, 32'h0, "R10 cleared");
        rd(12'h110, 32'h0, "R10 cleared");
        wr(12'h200, 32'd77);
        rd(12'h24C, 32'h0, "R9 edge+1");
        rd(12'h24C, 32'h0, "R9 edge+2");
        rd(12'h24C, 32'h1, "R9 set");
        wr(12'h204, 32'd0);
        wr(12'h208, 32'd8);
        wr(12'h240, 32'h0);
        wr(12'h100, 32'd1);
        wr(12'h104, 32'd0);
        idle(3);
        rd(12'h24C, 32'h0001_0007, "R9 all general");
        rd(12'h110, 32'h3, "R9 counter");
        wr(12'h24C, 32'h0);
        rd(12'h24C, 32'h0001_0007, "R10 write zero");
        wr(12'h24C, 32'h2);
        rd(12'h24C, 32'h0001_0005, "R10 clear one");
        wr(12'h110, 32'h1);
        rd(12'h110, 32'h2, "R10 counter clear");

        idle(3);
        if (q.size() != 0) begin
            n_err++;
            $display("FAIL scoreboard leftover actual %0d expected 0", q.size());
        end
        finish_run();
    end

    logic [11:0] reg_list [10] = '{12'h100, 12'h104, 12'h110, 12'h200, 12'h204,
                                   12'h208, 12'h240, 12'h244, 12'h248, 12'h24C};
endmodule